// File: doc/BRIEF.md
# Parallel configuration byte streamer

This block is the data side of a byte-wide configuration memory. A small internal byte array is filled through a synchronous write port, and a length register records the index of the last byte to send. Once streaming starts, the block puts one byte at a time on an 8-bit output, in ascending address order. The bytes are taken from an internal read pointer. That pointer steps forward only on clock edges the receiver can actually consume: chip enable low, the combined output-enable/reset input high, and the receiver's BUSY flag low.

Driving the output-enable/reset input low returns the read pointer to the first byte, so every fresh configuration attempt restarts the stream. When the byte at the last programmed address has been consumed, the block stops presenting data. It then pulls its chip-enable-out low so that a second streamer, chained behind it, continues the stream without a gap or a repeated byte. A high-impedance data bus is represented by an output-valid flag.

Top module: `cfg_byte_streamer`

## Requirements
- R1: After reset release with chip enable low, `dout` shows the stored byte at address 0. Each valid edge moves it to the next address in ascending order, and the byte changes only after the edge that consumes it.
- R2: While `busy` is high at a rising clock edge, that edge does not advance the pointer, and `dout` keeps the same byte.
- R3: While `ce_n` is high, `dout_vld` is low, `dout` is 0, and rising edges do not advance the pointer.
- R4: While `oe_rst_n` is low, the pointer is held at address 0 and the spent condition is cleared (asynchronously). `dout_vld` is low and `dout` is 0.
- R5: The edge that consumes the byte at address `len_last` makes the block spent. From then on `dout_vld` stays low and `dout` stays 0 until `oe_rst_n` goes low.
- R6: `ce_out_n` is low exactly when the block is spent and `ce_n` is low. Otherwise `ce_out_n` is high.
- R7: With `wr_en` high at a rising edge, `wr_data` is stored at `wr_addr`. With `len_we` high, `len_last` is stored as the last valid address. A value of 0 means a one-byte image.
- R8: When two streamers are chained, with the first one's `ce_out_n` driving the second one's `ce_n` and `busy` and `oe_rst_n` shared, the receiver sees the first image and then the second. Exactly one device is valid at a time, and no byte is skipped or repeated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Configuration clock |
| oe_rst_n | input | 1 | Output enable; low resets the read pointer (asynchronous) |
| ce_n | input | 1 | Active-low chip enable |
| busy | input | 1 | Receiver flow control; high stalls the stream |
| wr_en | input | 1 | Array write strobe |
| wr_addr | input | AW | Array write address |
| wr_data | input | 8 | Array write byte |
| len_we | input | 1 | Last-address register write strobe |
| len_last | input | AW | Index of the last byte to stream |
| dout | output | 8 | Current stream byte, 0 when not valid |
| dout_vld | output | 1 | High when the block drives the data bus |
| ce_out_n | output | 1 | Active-low enable for the next streamer in a chain |

## Verification
The bench chains two instances and follows a consumed-byte index in a reference model. It goes after the handoff edge, where a design that advanced once too far or one too few would skip or repeat a byte, or would leave both devices valid at once. Random BUSY stalls expose a pointer that moves or a byte that changes during a stall. A reset pulse in mid-stream catches a design that resumes from the old address instead of byte 0. A one-byte image and a stretch with chip enable high test the last-address compare at its smallest value, and check that a disabled chip neither drives nor advances.

// File: rtl/cbs_pkg.sv
package cbs_pkg;
    localparam int unsigned BYTE_W = 8;

    typedef enum logic {
        SQ_RUN   = 1'b0,
        SQ_SPENT = 1'b1
    } seq_st_e;
endpackage

// File: rtl/cbs_store.sv
module cbs_store #(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned DW    = 8,
    localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          len_we,
    input  logic [AW-1:0] len_last,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic [AW-1:0] last_addr
);
    logic [DW-1:0] mem_q [DEPTH];
    logic [AW-1:0] last_d, last_q;

    always_comb begin
        last_d = last_q;
        if (len_we) begin
            last_d = len_last;
        end
    end

    always_ff @(posedge clk) begin
        last_q <= last_d;
        if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    assign rd_data   = mem_q[rd_addr];
    assign last_addr = last_q;
endmodule

// File: rtl/cbs_sequencer.sv
module cbs_sequencer #(
    parameter int unsigned AW = 6
) (
    input  logic          clk,
    input  logic          oe_rst_n,
    input  logic          ce_n,
    input  logic          busy,
    input  logic [AW-1:0] last_addr,
    output logic [AW-1:0] rd_addr,
    output logic          spent
);
    import cbs_pkg::*;

    typedef struct packed {
        logic [AW-1:0] addr;
        seq_st_e       st;
    } seq_t;

    seq_t seq_d, seq_q;
    logic fire;

    always_comb begin
        seq_d = seq_q;
        fire  = !ce_n && !busy && (seq_q.st == SQ_RUN);
        if (fire) begin
            if (seq_q.addr == last_addr) begin
                seq_d.st = SQ_SPENT;
            end else begin
                seq_d.addr = AW'(seq_q.addr + 1'b1);
            end
        end
    end

    always_ff @(posedge clk or negedge oe_rst_n) begin
        if (!oe_rst_n) begin
            seq_q <= '{addr: '0, st: SQ_RUN};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign rd_addr = seq_q.addr;
    assign spent   = (seq_q.st == SQ_SPENT);

    // R2: a stalled edge changes nothing
    assert_busy_hold_R2: assert property (@(posedge clk) disable iff (!oe_rst_n)
        busy |=> ($stable(seq_q.addr) && $stable(seq_q.st)));

    // R3: disabled chip does not move
    assert_ce_hold_R3: assert property (@(posedge clk) disable iff (!oe_rst_n)
        ce_n |=> ($stable(seq_q.addr) && $stable(seq_q.st)));

    // R1: a consumed byte that is not the last steps the pointer by one
    assert_step_R1: assert property (@(posedge clk) disable iff (!oe_rst_n)
        (!ce_n && !busy && seq_q.st == SQ_RUN && seq_q.addr != last_addr)
        |=> (seq_q.addr == AW'($past(seq_q.addr) + 1'b1)));

    // R5: spent is sticky until reset
    assert_spent_sticky_R5: assert property (@(posedge clk) disable iff (!oe_rst_n)
        (seq_q.st == SQ_SPENT) |=> (seq_q.st == SQ_SPENT));

    // R4: reset holds the pointer at the first byte
    always @(posedge clk) begin
        if (!oe_rst_n) begin
            assert_rst_origin_R4: assert (seq_q.addr == '0 && seq_q.st == SQ_RUN);
        end
    end
endmodule

// File: rtl/cfg_byte_streamer.sv
module cfg_byte_streamer #(
    parameter int unsigned DEPTH = 64,
    localparam int unsigned DW   = cbs_pkg::BYTE_W,
    localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          oe_rst_n,
    input  logic          ce_n,
    input  logic          busy,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          len_we,
    input  logic [AW-1:0] len_last,
    output logic [DW-1:0] dout,
    output logic          dout_vld,
    output logic          ce_out_n
);
    logic [AW-1:0] rd_addr;
    logic [AW-1:0] last_addr;
    logic [DW-1:0] rd_data;
    logic          spent;

    cbs_store #(.DEPTH(DEPTH), .DW(DW)) i_store (
        .clk       (clk),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .len_we    (len_we),
        .len_last  (len_last),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .last_addr (last_addr)
    );

    cbs_sequencer #(.AW(AW)) i_seq (
        .clk       (clk),
        .oe_rst_n  (oe_rst_n),
        .ce_n      (ce_n),
        .busy      (busy),
        .last_addr (last_addr),
        .rd_addr   (rd_addr),
        .spent     (spent)
    );

    always_comb begin
        dout_vld = oe_rst_n && !ce_n && !spent;
        dout     = dout_vld ? rd_data : '0;
        ce_out_n = !(spent && !ce_n);
    end

    // R6: never hand off while disabled
    assert_ceo_idle_R6: assert property (@(posedge clk) disable iff (!oe_rst_n)
        ce_n |-> (ce_out_n && !dout_vld));

    // R5: a valid byte and a handoff never coexist
    assert_no_overlap_R5: assert property (@(posedge clk) disable iff (!oe_rst_n)
        dout_vld |-> ce_out_n);
endmodule

// File: tb/test_cfg_byte_streamer.sv
`timescale 1ns/1ps
module test_cfg_byte_streamer;
    localparam int DEPTH = 64;
    localparam int AW    = 6;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          oe_rst_n = 1'b0;
    logic          ce_n     = 1'b0;
    logic          busy     = 1'b0;
    logic          wr_en_a = 1'b0, wr_en_b = 1'b0;
    logic          len_we_a = 1'b0, len_we_b = 1'b0;
    logic [AW-1:0] wr_addr = '0, len_last = '0;
    logic [7:0]    wr_data = '0;
    logic [7:0]    dout_a, dout_b;
    logic          vld_a, vld_b, ceo_a, ceo_b;

    cfg_byte_streamer #(.DEPTH(DEPTH)) i_cfg_byte_streamer (
        .clk(clk), .oe_rst_n(oe_rst_n), .ce_n(ce_n), .busy(busy),
        .wr_en(wr_en_a), .wr_addr(wr_addr), .wr_data(wr_data),
        .len_we(len_we_a), .len_last(len_last),
        .dout(dout_a), .dout_vld(vld_a), .ce_out_n(ceo_a));

    cfg_byte_streamer #(.DEPTH(DEPTH)) i_cfg_byte_streamer_b (
        .clk(clk), .oe_rst_n(oe_rst_n), .ce_n(ceo_a), .busy(busy),
        .wr_en(wr_en_b), .wr_addr(wr_addr), .wr_data(wr_data),
        .len_we(len_we_b), .len_last(len_last),
        .dout(dout_b), .dout_vld(vld_b), .ce_out_n(ceo_b));

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    logic [7:0] img[$];
    int n_a = 0;
    int idx = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=<50000", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // R7: loads one image into one device
    task automatic load(input bit dev_b, input int n, input int seed);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            wr_addr = AW'(i);
            wr_data = 8'(seed + i * 37);
            wr_en_a = !dev_b;
            wr_en_b = dev_b;
            img.push_back(8'(seed + i * 37));
        end
        @(negedge clk);
        wr_en_a  = 1'b0;
        wr_en_b  = 1'b0;
        len_last = AW'(n - 1);
        len_we_a = !dev_b;
        len_we_b = dev_b;
        @(negedge clk);
        len_we_a = 1'b0;
        len_we_b = 1'b0;
    endtask

    // one clock: compare against the model, then drive the next edge
    task automatic step(input bit oe, input bit ce, input bit bsy, input string tag);
        int total;
        bit ea, eb, done;
        @(negedge clk);
        total = img.size();
        done  = oe_rst_n && !ce_n && idx >= total;
        ea = oe_rst_n && !ce_n && idx < n_a;
        eb = oe_rst_n && !ce_n && idx >= n_a && idx < total;
        chk(vld_a == ea, {tag, " vld_a"}, vld_a, ea);
        chk(vld_b == eb, {tag, " vld_b R8"}, vld_b, eb);
        chk(dout_a == (ea ? img[idx] : 8'h00), {tag, " dout_a R1"}, dout_a, ea ? img[idx] : 0);
        chk(dout_b == (eb ? img[idx] : 8'h00), {tag, " dout_b R1"}, dout_b, eb ? img[idx] : 0);
        chk(ceo_a == !(oe_rst_n && !ce_n && idx >= n_a), {tag, " ceo_a R6"}, ceo_a,
            !(oe_rst_n && !ce_n && idx >= n_a));
        chk(ceo_b == !done, {tag, " ceo_b R5"}, ceo_b, !done);
        oe_rst_n = oe;
        ce_n     = ce;
        busy     = bsy;
        if (!oe) idx = 0;
        else if (!ce && !bsy && idx < total) idx++;
    endtask

    initial begin
        // R7: first pair of images, 5 and 4 bytes
        load(1'b0, 5, 8'h11);
        n_a = 5;
        load(1'b1, 4, 8'hA0);

        // R4: outputs quiet while held in reset
        step(1'b0, 1'b0, 1'b0, "R4 reset");
        step(1'b1, 1'b0, 1'b1, "R4 release");

        // R1 R8: free-running stream across the handoff
        for (int i = 0; i < 14; i++) step(1'b1, 1'b0, 1'b0, "R1 stream");
        // R5: stays spent
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b0, "R5 spent");

        // R4: reset pulse, then R2 random stalls with a mid-stream reset
        step(1'b0, 1'b0, 1'b0, "R4 pulse");
        step(1'b1, 1'b0, 1'b1, "R4 restart");
        for (int i = 0; i < 60; i++) begin
            if (i == 12) step(1'b0, 1'b0, 1'b0, "R4 midstream");
            else step(1'b1, 1'b0, 1'($urandom % 2), "R2 stall");
        end

        // R3: chip enable high in mid-stream
        step(1'b0, 1'b0, 1'b0, "R4 pulse2");
        step(1'b1, 1'b0, 1'b0, "R3 pre");
        step(1'b1, 1'b0, 1'b0, "R3 pre");
        for (int i = 0; i < 4; i++) step(1'b1, 1'b1, 1'b0, "R3 disabled");
        for (int i = 0; i < 12; i++) step(1'b1, 1'b0, 1'b0, "R3 resume");

        // R7 R5: one-byte first image, three-byte second image
        step(1'b0, 1'b0, 1'b0, "R7 hold");
        img.delete();
        idx = 0;
        load(1'b0, 1, 8'h5C);
        n_a = 1;
        load(1'b1, 3, 8'h07);
        step(1'b0, 1'b0, 1'b0, "R7 hold");
        step(1'b1, 1'b0, 1'b1, "R7 release");
        for (int i = 0; i < 20; i++) step(1'b1, 1'b0, 1'($urandom % 2), "R5 single");
        step(1'b1, 1'b0, 1'b0, "R5 final");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule